// File: doc/BRIEF.md
# PHY Discovery and Setup Sequencer

This block runs once per start request and walks the 32 management addresses looking for attached transceivers. At each address it reads the status register and applies a presence test. For every transceiver it finds, it records the address, reads the control and advertisement registers, corrects the advertisement, and rewrites the control register for either autonegotiation or a forced speed and duplex. All register traffic goes through an external management-bus master over a request/response handshake. The serial wire protocol belongs to that master, not to this block.

When the walk ends, the block pulses `done` and presents the list of found addresses and how many there are. If the system expected at least one transceiver and none answered, a warning flag is raised and address 1 is placed in the first list slot as a fallback. The configuration inputs (`auto_mode`, `force_full`, `force_100`, `cfg_adv`, `expect_phy`) are captured when `start` is accepted and held for the whole walk.

Top module: `phy_scan_seq`

## Requirements
- R1: Addresses are probed in the order 1, 2, …, 31 and then 0. Each probe begins with a read of register 1 (status). Found addresses fill the list in probe order, with slot i at `phy_list[5*i +: 5]`.
- R2: An address counts as present when (status & 0x8301) == 0x8001, or when status bit 15 is clear and (status & 0x7800) != 0. An absent address gets no further requests.
- R3: Once `MAX_PHYS` addresses have been recorded, no further address is probed and `phy_count` never exceeds `MAX_PHYS`.
- R4: The current advertisement is the value read from register 4. If that value has none of bits 8:5 (mask 0x01E0) set, it is replaced by ((status >> 6) & 0x03E0) | 1. The chosen advertisement is `cfg_adv` when that is nonzero, otherwise the current one. Register 4 is written with the chosen value only when the two differ.
- R5: In auto mode, bit 12 (0x1000) of the control word is set. If that changes the word, bit 9 (0x0200) is also set and a mode switch is noted. In forced mode, bit 12 is cleared, and a switch is noted if the word changed.
- R6: Bits 15, 14, 13, 11, 10, 8 and 7 (mask 0xED80) are then cleared. After that, bit 8 is set when `force_full` is high and bit 13 when `force_100` is high. No control write ever carries bits 15, 14, 11, 10 or 7.
- R7: Register 0 is written only when the new control word differs from the value read. Without a mode switch it is written exactly once.
- R8: With a mode switch, the same control word is written twice. The second request is issued no sooner than CLK_MHZ*GAP_US cycles after the first write's response.
- R9: When a walk ends with no address found and `expect_phy` was high at start, `none_found` is set and slot 0 holds address 1. With `expect_phy` low, `none_found` stays low and slot 0 stays 0.
- R10: `busy` is high from the cycle after `start` until the walk ends. `done` is a single-cycle pulse, and `phy_count` and `phy_list` are valid while it is high.
- R11: A request holds its fields stable while `req_valid` is high and `req_ready` is low. After acceptance, no new request is issued until `rsp_valid` returns. No request is made while idle.
- R12: After reset, `busy`, `done`, `req_valid`, `none_found` and `phy_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (accepted while idle) |
| auto_mode | input | 1 | 1: enable autonegotiation, 0: forced media |
| force_full | input | 1 | Request full duplex in the control word |
| force_100 | input | 1 | Request 100 Mb/s in the control word |
| cfg_adv | input | 16 | Configured advertisement, 0 = use the transceiver's own |
| expect_phy | input | 1 | A transceiver is expected to be present |
| req_valid | output | 1 | Management request valid |
| req_ready | input | 1 | Master accepts the request |
| req_write | output | 1 | 1: write, 0: read |
| req_phy | output | 5 | Transceiver address |
| req_reg | output | 5 | Register number |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Response (read data or write completion) |
| rsp_rdata | input | 16 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| phy_count | output | $clog2(MAX_PHYS+1) | Number of addresses found |
| phy_list | output | 5*MAX_PHYS | Found addresses, slot i at bits 5i+4:5i |
| none_found | output | 1 | Expected transceiver missing |

## Verification
Each response is consumed on the rising edge after `rsp_valid`, and the next request appears in the following cycle. The end-of-walk pulse arrives two cycles after the last response. The bench's bus model replies one cycle after acceptance, logs the cycle in which each request is seen, and checks the duplicate control write against a window from CLK_MHZ*GAP_US to CLK_MHZ*GAP_US+8 cycles after the first. Results are sampled on falling edges: list, count and flag in the cycle where `done` is high, and the pulse width on the next falling edge.

// File: rtl/phy_scan_pkg.sv
// Shared register numbers, bit masks and sequencer states for the PHY
// discovery sequencer. Assumes standard clause-22 register layout.
package phy_scan_pkg;

    localparam logic [4:0]  REG_CTRL       = 5'd0;
    localparam logic [4:0]  REG_STATUS     = 5'd1;
    localparam logic [4:0]  REG_ADVERT     = 5'd4;

    localparam logic [15:0] CTL_AN_EN      = 16'h1000;
    localparam logic [15:0] CTL_AN_RESTART = 16'h0200;
    localparam logic [15:0] CTL_FULL       = 16'h0100;
    localparam logic [15:0] CTL_SPEED100   = 16'h2000;
    localparam logic [15:0] CTL_SCRUB      = 16'hED80;

    localparam logic [15:0] ST_PROBE_MASK  = 16'h8301;
    localparam logic [15:0] ST_PROBE_MATCH = 16'h8001;
    localparam logic [15:0] ST_T4          = 16'h8000;
    localparam logic [15:0] ST_ABILITY     = 16'h7800;

    localparam logic [15:0] ADV_ABILITY    = 16'h01E0;
    localparam logic [15:0] ADV_FROM_ST    = 16'h03E0;
    localparam logic [15:0] ADV_SELECTOR   = 16'h0001;

    typedef enum logic [4:0] {
        S_IDLE, S_RD_STAT, S_WT_STAT, S_RD_CTL, S_WT_CTL, S_RD_ADV, S_WT_ADV,
        S_DECIDE, S_WR_ADV, S_WT_WADV, S_WR_CTL1, S_WT_CTL1, S_GAP,
        S_WR_CTL2, S_WT_CTL2, S_NEXT, S_FINISH
    } scan_state_t;

endpackage

// File: rtl/phy_presence_eval.sv
// Presence test on a status word. Purely combinational; assumes the word
// is the value just read from register 1 of the probed address.
module phy_presence_eval
    import phy_scan_pkg::*;
(
    input  logic [15:0] status_word,
    output logic        present
);

    // Either the basic pattern matches or some 10/100 ability bit is set without T4.
    always_comb begin
        present = ((status_word & ST_PROBE_MASK) == ST_PROBE_MATCH) ||
                  (((status_word & ST_T4) == 16'h0) && ((status_word & ST_ABILITY) != 16'h0));
    end

endmodule

// File: rtl/phy_adv_select.sv
// Picks the advertisement to program. Combinational; assumes status and
// advertisement words were captured from the same transceiver.
module phy_adv_select
    import phy_scan_pkg::*;
(
    input  logic [15:0] status_word,
    input  logic [15:0] phy_adv,
    input  logic [15:0] cfg_adv,
    output logic [15:0] chosen_adv,
    output logic        adv_write
);

    logic [15:0] built_adv;
    logic [15:0] cur_adv;

    // Derive a fallback from status, choose the source, flag a needed write.
    always_comb begin
        built_adv  = ((status_word >> 6) & ADV_FROM_ST) | ADV_SELECTOR;
        cur_adv    = ((phy_adv & ADV_ABILITY) == 16'h0) ? built_adv : phy_adv;
        chosen_adv = (cfg_adv != 16'h0) ? cfg_adv : cur_adv;
        adv_write  = (chosen_adv != cur_adv);
    end

endmodule

// File: rtl/phy_ctl_rewrite.sv
// Computes the new control word from the one read back. Combinational;
// assumes the mode and force inputs are stable for the whole walk.
module phy_ctl_rewrite
    import phy_scan_pkg::*;
(
    input  logic [15:0] ctl_old,
    input  logic        auto_mode,
    input  logic        force_full,
    input  logic        force_100,
    output logic [15:0] ctl_new,
    output logic        an_switch,
    output logic        ctl_write
);

    logic [15:0] stage;

    // Apply the autoneg rule, scrub unwanted bits, then add the forced settings.
    always_comb begin
        if (auto_mode) begin
            stage     = ctl_old | CTL_AN_EN;
            an_switch = (stage != ctl_old);
            if (an_switch) begin
                stage = stage | CTL_AN_RESTART;
            end
        end else begin
            stage     = ctl_old & ~CTL_AN_EN;
            an_switch = (stage != ctl_old);
        end
        ctl_new = (stage & ~CTL_SCRUB)
                | (force_full ? CTL_FULL : 16'h0)
                | (force_100  ? CTL_SPEED100 : 16'h0);
        ctl_write = (ctl_new != ctl_old);
    end

endmodule

// File: rtl/phy_gap_timer.sv
// Down-counter that spaces the duplicate control writes. Assumes
// GAP_CYCLES >= 1; expired is high whenever the count is zero.
module phy_gap_timer #(
    parameter int GAP_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(GAP_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Flag the end of the wait.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/phy_scan_seq.sv
// PHY discovery and setup sequencer. On start, walks addresses 1..31 then 0,
// tests presence, fixes the advertisement and rewrites the control word of
// each found transceiver through a request/response management master.
// Assumes the master answers every request (read or write) with rsp_valid.
module phy_scan_seq
    import phy_scan_pkg::*;
#(
    parameter int MAX_PHYS = 4,
    parameter int CLK_MHZ  = 200,
    parameter int GAP_US   = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              auto_mode,
    input  logic                              force_full,
    input  logic                              force_100,
    input  logic [15:0]                       cfg_adv,
    input  logic                              expect_phy,
    output logic                              req_valid,
    input  logic                              req_ready,
    output logic                              req_write,
    output logic [4:0]                        req_phy,
    output logic [4:0]                        req_reg,
    output logic [15:0]                       req_wdata,
    input  logic                              rsp_valid,
    input  logic [15:0]                       rsp_rdata,
    output logic                              busy,
    output logic                              done,
    output logic [$clog2(MAX_PHYS+1)-1:0]     phy_count,
    output logic [5*MAX_PHYS-1:0]             phy_list,
    output logic                              none_found
);

    localparam int GAP_CYCLES = CLK_MHZ * GAP_US;
    localparam int CNT_W      = $clog2(MAX_PHYS + 1);

    scan_state_t      state_q;
    logic [4:0]       scan_idx_q;
    logic [4:0]       cur_addr;
    logic [CNT_W-1:0] count_q;
    logic [15:0]      status_q;
    logic [15:0]      ctl_q;
    logic [15:0]      adv_q;
    logic             auto_q;
    logic             full_q;
    logic             f100_q;
    logic [15:0]      cfg_adv_q;
    logic             expect_q;
    logic             done_q;
    logic             none_q;

    logic             rsp_present;
    logic [15:0]      chosen_adv;
    logic             adv_write;
    logic [15:0]      ctl_new;
    logic             an_switch;
    logic             ctl_write;
    logic             gap_load;
    logic             gap_expired;
    logic             accepted;
    logic             list_full;
    logic             walk_start;
    logic             empty_fallback;

    // Current address: index 0..30 maps to 1..31, index 31 wraps to 0.
    always_comb begin
        cur_addr       = scan_idx_q + 5'd1;
        accepted       = req_valid && req_ready;
        list_full      = (count_q == CNT_W'(MAX_PHYS));
        walk_start     = (state_q == S_IDLE) && start;
        empty_fallback = (state_q == S_FINISH) && (count_q == '0) && expect_q;
        gap_load       = (state_q == S_WT_CTL1) && rsp_valid && an_switch;
    end

    phy_presence_eval u_presence (
        .status_word (rsp_rdata),
        .present     (rsp_present)
    );

    phy_adv_select u_adv (
        .status_word (status_q),
        .phy_adv     (adv_q),
        .cfg_adv     (cfg_adv_q),
        .chosen_adv  (chosen_adv),
        .adv_write   (adv_write)
    );

    phy_ctl_rewrite u_ctl (
        .ctl_old    (ctl_q),
        .auto_mode  (auto_q),
        .force_full (full_q),
        .force_100  (f100_q),
        .ctl_new    (ctl_new),
        .an_switch  (an_switch),
        .ctl_write  (ctl_write)
    );

    phy_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    // Sequencer state, walk index and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            scan_idx_q <= '0;
            auto_q     <= 1'b0;
            full_q     <= 1'b0;
            f100_q     <= 1'b0;
            cfg_adv_q  <= '0;
            expect_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        scan_idx_q <= '0;
                        auto_q     <= auto_mode;
                        full_q     <= force_full;
                        f100_q     <= force_100;
                        cfg_adv_q  <= cfg_adv;
                        expect_q   <= expect_phy;
                        state_q    <= S_RD_STAT;
                    end
                end
                S_RD_STAT: if (accepted) state_q <= S_WT_STAT;
                S_WT_STAT: begin
                    if (rsp_valid) begin
                        state_q <= rsp_present ? S_RD_CTL : S_NEXT;
                    end
                end
                S_RD_CTL:  if (accepted) state_q <= S_WT_CTL;
                S_WT_CTL:  if (rsp_valid) state_q <= S_RD_ADV;
                S_RD_ADV:  if (accepted) state_q <= S_WT_ADV;
                S_WT_ADV:  if (rsp_valid) state_q <= S_DECIDE;
                S_DECIDE: begin
                    if (adv_write) begin
                        state_q <= S_WR_ADV;
                    end else if (ctl_write) begin
                        state_q <= S_WR_CTL1;
                    end else begin
                        state_q <= S_NEXT;
                    end
                end
                S_WR_ADV:  if (accepted) state_q <= S_WT_WADV;
                S_WT_WADV: begin
                    if (rsp_valid) begin
                        state_q <= ctl_write ? S_WR_CTL1 : S_NEXT;
                    end
                end
                S_WR_CTL1: if (accepted) state_q <= S_WT_CTL1;
                S_WT_CTL1: begin
                    if (rsp_valid) begin
                        state_q <= an_switch ? S_GAP : S_NEXT;
                    end
                end
                S_GAP:     if (gap_expired) state_q <= S_WR_CTL2;
                S_WR_CTL2: if (accepted) state_q <= S_WT_CTL2;
                S_WT_CTL2: if (rsp_valid) state_q <= S_NEXT;
                S_NEXT: begin
                    if ((scan_idx_q == 5'd31) || list_full) begin
                        state_q <= S_FINISH;
                    end else begin
                        scan_idx_q <= scan_idx_q + 5'd1;
                        state_q    <= S_RD_STAT;
                    end
                end
                S_FINISH:  state_q <= S_IDLE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    // Capture read data into the register it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            ctl_q    <= '0;
            adv_q    <= '0;
        end else if (rsp_valid) begin
            if (state_q == S_WT_STAT) status_q <= rsp_rdata;
            if (state_q == S_WT_CTL)  ctl_q    <= rsp_rdata;
            if (state_q == S_WT_ADV)  adv_q    <= rsp_rdata;
        end
    end

    // Found-address count: cleared at start, bumped when an address is recorded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (walk_start) begin
            count_q <= '0;
        end else if (state_q == S_DECIDE) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // End-of-walk pulse and missing-transceiver flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            none_q <= 1'b0;
        end else begin
            done_q <= (state_q == S_FINISH);
            if (walk_start) begin
                none_q <= 1'b0;
            end else if (empty_fallback) begin
                none_q <= 1'b1;
            end
        end
    end

    // One register per list slot, written when the count points at it.
    for (genvar g = 0; g < MAX_PHYS; g++) begin : g_slot
        logic [4:0] slot_q;

        // Record the address, clear at start, default slot 0 to address 1 if empty.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (walk_start) begin
                slot_q <= '0;
            end else if ((state_q == S_DECIDE) && (count_q == CNT_W'(g))) begin
                slot_q <= cur_addr;
            end else if ((g == 0) && empty_fallback) begin
                slot_q <= 5'd1;
            end
        end

        assign phy_list[g*5 +: 5] = slot_q;
    end

    // Drive the management request from the current state.
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_reg   = REG_CTRL;
        req_wdata = 16'h0;
        case (state_q)
            S_RD_STAT: begin
                req_valid = 1'b1;
                req_reg   = REG_STATUS;
            end
            S_RD_CTL: begin
                req_valid = 1'b1;
                req_reg   = REG_CTRL;
            end
            S_RD_ADV: begin
                req_valid = 1'b1;
                req_reg   = REG_ADVERT;
            end
            S_WR_ADV: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_reg   = REG_ADVERT;
                req_wdata = chosen_adv;
            end
            S_WR_CTL1, S_WR_CTL2: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_reg   = REG_CTRL;
                req_wdata = ctl_new;
            end
            default: begin
                req_valid = 1'b0;
            end
        endcase
        req_phy    = cur_addr;
        busy       = (state_q != S_IDLE);
        done       = done_q;
        none_found = none_q;
        phy_count  = count_q;
    end

endmodule

// File: rtl/phy_scan_seq_chk.sv
// Property checker for the PHY discovery sequencer, bound to its top.
module phy_scan_seq_chk #(
    parameter int MAX_PHYS = 4,
    parameter int CNT_W    = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_write,
    input logic [4:0]            req_phy,
    input logic [4:0]            req_reg,
    input logic [15:0]           req_wdata,
    input logic                  busy,
    input logic                  done,
    input logic [CNT_W-1:0]      phy_count,
    input logic [5*MAX_PHYS-1:0] phy_list,
    input logic                  none_found
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_phy)
            && $stable(req_reg) && $stable(req_wdata)); // R11

    AST_WAIT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R11

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        phy_count <= CNT_W'(MAX_PHYS)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done && none_found |-> (phy_count == '0) && (phy_list[4:0] == 5'd1)); // R9

    AST_CTL_SCRUB: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && (req_reg == 5'd0) |-> ((req_wdata & 16'hCC80) == 16'h0)); // R6

endmodule

bind phy_scan_seq phy_scan_seq_chk #(
    .MAX_PHYS (MAX_PHYS),
    .CNT_W    ($clog2(MAX_PHYS+1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_phy    (req_phy),
    .req_reg    (req_reg),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .done       (done),
    .phy_count  (phy_count),
    .phy_list   (phy_list),
    .none_found (none_found)
);

// File: tb/phy_scan_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: a management-bus model holds per-address registers,
// logs every request, and each scenario task checks its own results.
module phy_scan_seq_bench;

    localparam int MAXP    = 4;
    localparam int CLK_MHZ = 200;
    localparam int GAP_US  = 10;
    localparam int GAPC    = CLK_MHZ * GAP_US;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        auto_mode = 1'b1;
    logic        force_full = 1'b0;
    logic        force_100 = 1'b0;
    logic [15:0] cfg_adv = 16'h0;
    logic        expect_phy = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic        req_write;
    logic [4:0]  req_phy;
    logic [4:0]  req_reg;
    logic [15:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_rdata = 16'h0;
    logic        busy;
    logic        done;
    logic [2:0]  phy_count;
    logic [5*MAXP-1:0] phy_list;
    logic        none_found;

    phy_scan_seq #(.MAX_PHYS(MAXP), .CLK_MHZ(CLK_MHZ), .GAP_US(GAP_US)) u_phy_scan_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .auto_mode(auto_mode),
        .force_full(force_full), .force_100(force_100), .cfg_adv(cfg_adv),
        .expect_phy(expect_phy), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .busy(busy), .done(done), .phy_count(phy_count), .phy_list(phy_list),
        .none_found(none_found)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    logic [15:0] m_stat [32];
    logic [15:0] m_ctl  [32];
    logic [15:0] m_adv  [32];
    int          ctl_rd [32];
    logic [4:0]  s_order [64];
    int          n_stat = 0;
    logic [4:0]  w_phy [64];
    logic [4:0]  w_reg [64];
    logic [15:0] w_dat [64];
    int          w_cyc [64];
    int          n_wr = 0;

    logic [2:0]        got_cnt;
    logic [5*MAXP-1:0] got_list;
    logic              got_none;

    initial forever #2.5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // Bus model: reply one cycle after acceptance, log every request.
    initial begin
        logic        pend;
        logic [15:0] pdat;
        pend = 1'b0;
        pdat = 16'h0;
        forever begin
            @(negedge clk);
            if (pend) begin
                rsp_valid = 1'b1;
                rsp_rdata = pdat;
                pend = 1'b0;
            end else begin
                rsp_valid = 1'b0;
                if (req_valid && req_ready) begin
                    pend = 1'b1;
                    pdat = 16'h0;
                    if (req_write) begin
                        if (n_wr < 64) begin
                            w_phy[n_wr] = req_phy;
                            w_reg[n_wr] = req_reg;
                            w_dat[n_wr] = req_wdata;
                            w_cyc[n_wr] = cyc;
                        end
                        n_wr++;
                        if (req_reg == 5'd0) m_ctl[req_phy] = req_wdata;
                        if (req_reg == 5'd4) m_adv[req_phy] = req_wdata;
                    end else begin
                        case (req_reg)
                            5'd1: begin
                                if (n_stat < 64) s_order[n_stat] = req_phy;
                                n_stat++;
                                pdat = m_stat[req_phy];
                            end
                            5'd0: begin
                                ctl_rd[req_phy]++;
                                pdat = m_ctl[req_phy];
                            end
                            5'd4: pdat = m_adv[req_phy];
                            default: pdat = 16'hFFFF;
                        endcase
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic clear_phys();
        for (int i = 0; i < 32; i++) begin
            m_stat[i] = 16'hFFFF;
            m_ctl[i]  = 16'h0;
            m_adv[i]  = 16'h0;
            ctl_rd[i] = 0;
        end
        n_stat = 0;
        n_wr   = 0;
    endtask

    task automatic chk_write(input string req, input int k, input logic [4:0] p,
                             input logic [4:0] r, input logic [15:0] d);
        chk_eq({req, " write addr"}, 32'(w_phy[k]), 32'(p));
        chk_eq({req, " write reg"},  32'(w_reg[k]), 32'(r));
        chk_eq({req, " write data"}, 32'(w_dat[k]), 32'(d));
    endtask

    // Start a walk, check busy, wait for done, capture results, check pulse width.
    task automatic run_scan();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R10 busy after start", 32'(busy), 32'd1);
        while (!done) @(negedge clk);
        got_cnt  = phy_count;
        got_list = phy_list;
        got_none = none_found;
        @(negedge clk);
        chk_eq("R10 done one cycle", 32'(done), 32'd0);
        chk_eq("R10 idle after done", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        chk_eq("R12 busy", 32'(busy), 32'd0);
        chk_eq("R12 done", 32'(done), 32'd0);
        chk_eq("R12 req_valid", 32'(req_valid), 32'd0);
        chk_eq("R12 none_found", 32'(none_found), 32'd0);
        chk_eq("R12 count", 32'(phy_count), 32'd0);
    endtask

    task automatic t_empty_expected();
        clear_phys();
        expect_phy = 1'b1;
        run_scan();
        chk_eq("R9 none_found set", 32'(got_none), 32'd1);
        chk_eq("R9 slot0 default", 32'(got_list[4:0]), 32'd1);
        chk_eq("R9 count zero", 32'(got_cnt), 32'd0);
        chk_eq("R1 all probed", 32'(n_stat), 32'd32);
        chk_eq("R1 first address", 32'(s_order[0]), 32'd1);
        chk_eq("R1 address 31 before 0", 32'(s_order[30]), 32'd31);
        chk_eq("R1 last address", 32'(s_order[31]), 32'd0);
        chk_eq("R2 absent no writes", 32'(n_wr), 32'd0);
    endtask

    task automatic t_empty_unexpected();
        clear_phys();
        expect_phy = 1'b0;
        run_scan();
        chk_eq("R9 no flag when not expected", 32'(got_none), 32'd0);
        chk_eq("R9 slot0 stays 0", 32'(got_list[4:0]), 32'd0);
    endtask

    task automatic t_auto_mixed();
        clear_phys();
        expect_phy = 1'b1;
        auto_mode  = 1'b1;
        force_full = 1'b0;
        force_100  = 1'b0;
        cfg_adv    = 16'h0;
        m_stat[3] = 16'h786D; m_ctl[3] = 16'h0000; m_adv[3] = 16'h01E1;
        m_stat[5] = 16'h8001; m_ctl[5] = 16'h5000; m_adv[5] = 16'h0001;
        m_stat[0] = 16'h7809; m_ctl[0] = 16'h1000; m_adv[0] = 16'h01E1;
        m_stat[7] = 16'h8101;
        m_stat[9] = 16'h0004;
        run_scan();
        chk_eq("R1 count", 32'(got_cnt), 32'd3);
        chk_eq("R1 slot0", 32'(got_list[4:0]), 32'd3);
        chk_eq("R1 slot1", 32'(got_list[9:5]), 32'd5);
        chk_eq("R1 slot2", 32'(got_list[14:10]), 32'd0);
        chk_eq("R2 T4 pattern rejected", 32'(ctl_rd[7]), 32'd0);
        chk_eq("R2 no ability rejected", 32'(ctl_rd[9]), 32'd0);
        chk_eq("R2 ability rule accepted", 32'(ctl_rd[3]), 32'd1);
        chk_eq("R9 flag clear when found", 32'(got_none), 32'd0);
        chk_eq("R7 write total", 32'(n_wr), 32'd3);
        chk_write("R5 autoneg enable restart", 0, 5'd3, 5'd0, 16'h1200);
        chk_write("R8 duplicate write", 1, 5'd3, 5'd0, 16'h1200);
        chk(((w_cyc[1] - w_cyc[0]) >= GAPC) && ((w_cyc[1] - w_cyc[0]) <= GAPC + 8),
            "R8 gap between writes", 32'(w_cyc[1] - w_cyc[0]), 32'(GAPC));
        chk_write("R6 loopback scrubbed single write", 2, 5'd5, 5'd0, 16'h1000);
    endtask

    task automatic t_forced_full_list();
        clear_phys();
        expect_phy = 1'b1;
        auto_mode  = 1'b0;
        force_full = 1'b1;
        force_100  = 1'b1;
        cfg_adv    = 16'h05E1;
        for (int a = 1; a <= 6; a++) m_stat[a] = 16'h7809;
        m_ctl[1] = 16'h1000; m_adv[1] = 16'h01E1;
        m_ctl[2] = 16'h2100; m_adv[2] = 16'h05E1;
        m_ctl[3] = 16'h3100; m_adv[3] = 16'h0000;
        m_ctl[4] = 16'h2900; m_adv[4] = 16'h05E1;
        run_scan();
        chk_eq("R3 count saturates", 32'(got_cnt), 32'd4);
        chk_eq("R3 probing stops", 32'(n_stat), 32'd4);
        chk_eq("R3 list", 32'(got_list), 32'({5'd4, 5'd3, 5'd2, 5'd1}));
        chk_eq("R7 write total", 32'(n_wr), 32'd7);
        chk_write("R4 configured adv wins", 0, 5'd1, 5'd4, 16'h05E1);
        chk_write("R5 forced clears AN", 1, 5'd1, 5'd0, 16'h2100);
        chk_write("R8 forced duplicate", 2, 5'd1, 5'd0, 16'h2100);
        chk_write("R4 adv after build differs", 3, 5'd3, 5'd4, 16'h05E1);
        chk_write("R6 forced duplex speed", 4, 5'd3, 5'd0, 16'h2100);
        chk_write("R8 second duplicate", 5, 5'd3, 5'd0, 16'h2100);
        chk_write("R7 single write no switch", 6, 5'd4, 5'd0, 16'h2100);
    endtask

    task automatic t_last_before_zero();
        clear_phys();
        expect_phy = 1'b0;
        auto_mode  = 1'b0;
        force_full = 1'b0;
        force_100  = 1'b0;
        cfg_adv    = 16'h0;
        m_stat[31] = 16'h7809; m_ctl[31] = 16'h0000; m_adv[31] = 16'h0000;
        run_scan();
        chk_eq("R1 count one", 32'(got_cnt), 32'd1);
        chk_eq("R1 slot0 is 31", 32'(got_list[4:0]), 32'd31);
        chk_eq("R1 walk reaches 0", 32'(s_order[31]), 32'd0);
        chk_eq("R4 built adv matches no write", 32'(n_wr), 32'd0);
    endtask

    initial begin
        clear_phys();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_expected();
        t_empty_unexpected();
        t_auto_mixed();
        t_forced_full_list();
        t_last_before_zero();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule